// File: doc/BRIEF.md
# Dual-Channel Expiry Watchdog

This block holds two independent watchdog channels behind a small word-addressed register port. Each channel has a 15-bit elapsed-time counter that goes up by one on every time-base tick and a 15-bit limit. A prescaler divides the system clock down to one tick per 10 ms. When a channel's counter reaches its limit, it stops and stays there until software writes to that channel again. Any write to a channel clears its counter, so a periodic write is what keeps the channel from expiring.

The two channels do different things when they expire. Channel 0 can be armed to send a one-cycle reset request to the system reset generator. Channel 1 can be armed to raise a level output. That output tells the packet engine to discard traffic headed for the CPU and to stop flow control on every port. The reset generator and the packet engine sit outside this block.

Top module: `wdog_dual`

## Requirements
- R1: After reset, both channel registers read 0, and `sysRstReq` and `pktGuard` are low.
- R2: Channel 0 is at address 0xC0 and channel 1 at 0xC4. Each reads as {arm bit [31], limit [30:16], 0 [15], count [14:0]}. Any other address reads 0, and writes to it change neither channel.
- R3: A write to a channel does three things in the same clock edge: it stores data bits 30:16 as the limit and bit 31 as the arm bit, and it clears the count to 0.
- R4: The time-base tick fires once every `TICK_DIV` clocks. On each tick, a count that is below its limit goes up by exactly one.
- R5: A count never goes above its limit. Once it equals the limit, it stays there until the channel is written.
- R6: If channel 0 is armed (bit 31 = 1), `sysRstReq` is high for exactly one clock, in the first cycle that the count equals the limit. If channel 0 is not armed, `sysRstReq` stays low.
- R7: If channel 1 is armed, `pktGuard` is high whenever its count equals a non-zero limit. `pktGuard` drops at the write edge of any write that clears the count or clears the arm bit.
- R8: A limit of 0 disables the channel: the count stays at 0 and the channel never expires.
- R9: Writing one channel does not change the count, limit or arm bit of the other channel.
- R10: Bit 15 ignores writes and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Byte address of the register access |
| regWrEn | input | 1 | Write strobe, one write per cycle it is high |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`; combinational |
| sysRstReq | output | 1 | One-cycle reset request when channel 0 expires |
| pktGuard | output | 1 | Level output: channel 1 has expired while armed |

## Verification
The bench goes after the expiry edge. It counts the cycles in which `sysRstReq` is high: a design that compared with `>=`, or that did not hold the count at the limit, would keep pulsing or would run past the limit. The bench checks counts after whole multiples of `TICK_DIV` from a write edge. An off-by-one prescaler, or a write that does not cancel a tick falling on the same edge, shows up as a wrong count. It also covers a zero limit, the bit 15 readback and a write to an unmapped address. A design that decoded the address loosely, or that cleared both channels on one write, would corrupt the channel it was not meant to touch.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic              tick;
    logic [NUM_CH-1:0] wrHit;
    logic [NUM_CH-1:0] rdHit;
  } wdStrobe_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int          TICK_DIV  = 1250000,
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  BASE_ADDR = 8'hC0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output wdStrobe_t         strb
);
  localparam int PRE_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int STRIDE = 4;

  logic [PRE_W-1:0] preCnt;
  logic             preWrap;

  assign preWrap = (preCnt == PRE_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preCnt <= '0;
    else if (preWrap) preCnt <= '0;
    else              preCnt <= preCnt + 1'b1;
  end

  assign strb.tick = preWrap;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    logic hit;
    assign hit           = (regAddr == ADDR_W'(BASE_ADDR + g * STRIDE));
    assign strb.rdHit[g] = hit;
    assign strb.wrHit[g] = hit && regWrEn;
  end

  if (TICK_DIV > 1) begin : g_tickChk
    // R4
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.tick |=> !strb.tick);
  end

  // R2
  single_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.wrHit));
endmodule

// File: rtl/wdog_path.sv
module wdog_path
  import wdog_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdStrobe_t         strb,
  input  logic [2*CNT_W+1:0] regWrData,
  output logic [2*CNT_W+1:0] regRdData,
  output logic              sysRstReq,
  output logic              pktGuard
);
  localparam int REG_W  = 2 * CNT_W + 2;
  localparam int THR_LO = CNT_W + 1;
  localparam int ARM_B  = REG_W - 1;

  logic [CNT_W-1:0] cnt [NUM_CH];
  logic [CNT_W-1:0] thr [NUM_CH];
  logic             arm [NUM_CH];
  logic             rsvdUnused;

  assign rsvdUnused = regWrData[CNT_W];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt[g] <= '0;
        thr[g] <= '0;
        arm[g] <= 1'b0;
      end else if (strb.wrHit[g]) begin
        cnt[g] <= '0;
        thr[g] <= regWrData[ARM_B-1:THR_LO];
        arm[g] <= regWrData[ARM_B];
      end else if (strb.tick && (cnt[g] != thr[g])) begin
        cnt[g] <= cnt[g] + 1'b1;
      end
    end

    // R3
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.wrHit[g] |=> (cnt[g] == '0));
    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      cnt[g] <= thr[g]);
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cnt[g] == thr[g] && !strb.wrHit[g]) |=> $stable(cnt[g]));
    // R4
    step_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.tick && !strb.wrHit[g] && cnt[g] < thr[g])
        |=> (cnt[g] == $past(cnt[g]) + 1'b1));
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (strb.rdHit[i]) regRdData = {arm[i], thr[i], 1'b0, cnt[i]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sysRstReq <= 1'b0;
    else       sysRstReq <= arm[0] && strb.tick && !strb.wrHit[0]
                            && (thr[0] != '0) && (cnt[0] != thr[0])
                            && ((cnt[0] + 1'b1) == thr[0]);
  end

  assign pktGuard = arm[1] && (thr[1] != '0) && (cnt[1] == thr[1]);

  // R6
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |=> !sysRstReq);
  // R6
  rst_at_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |-> (cnt[0] == thr[0] && arm[0]));
  // R7
  guard_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrHit[1] && regWrData[ARM_B-1:THR_LO] != '0) |=> !pktGuard);
endmodule

// File: rtl/wdog_dual.sv
module wdog_dual
  import wdog_pkg::*;
#(
  parameter int TICK_DIV = 1250000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        sysRstReq,
  output logic        pktGuard
);
  wdStrobe_t strb;

  wdog_ctrl #(
    .TICK_DIV (TICK_DIV),
    .ADDR_W   (8),
    .BASE_ADDR(8'hC0)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strb   (strb)
  );

  wdog_path #(
    .CNT_W(15)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .sysRstReq(sysRstReq),
    .pktGuard (pktGuard)
  );
endmodule

// File: tb/wdog_dual_bench.sv
module wdog_dual_bench;
  localparam int DIV = 4;
  localparam logic [7:0] A0 = 8'hC0;
  localparam logic [7:0] A1 = 8'hC4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        sysRstReq;
  logic        pktGuard;

  int checks = 0;
  int errors = 0;
  int pulseCycles = 0;
  bit done = 1'b0;

  wdog_dual #(.TICK_DIV(DIV)) u_wdog_dual (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .sysRstReq(sysRstReq), .pktGuard(pktGuard)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (rstN && sysRstReq) pulseCycles++;

  function automatic logic [31:0] enc(logic a, logic [14:0] t, logic [14:0] c);
    return {a, t, 1'b0, c};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic doRead(logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitTicks(int k);
    repeat (k * DIV) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    doRead(A0, d); check("R1 ch0", d, 32'h0);
    doRead(A1, d); check("R1 ch1", d, 32'h0);
    check("R1 outputs", {30'h0, sysRstReq, pktGuard}, 32'h0);
  endtask

  task automatic testLayout();
    logic [31:0] d;
    doWrite(A0, 32'h0005_8000);
    doRead(A0, d); check("R10 bit15 reads 0", d, enc(1'b0, 15'd5, 15'd0));
    doWrite(A0, 32'h0000_0000);
    doWrite(A1, 32'h0000_0000);
    doWrite(8'h10, 32'hFFFF_FFFF);
    doRead(8'h10, d); check("R2 unmapped read", d, 32'h0);
    doRead(A0, d); check("R2 unmapped write ch0", d, 32'h0);
    doRead(A1, d); check("R2 unmapped write ch1", d, 32'h0);
  endtask

  task automatic testCount();
    logic [31:0] d;
    doWrite(A0, {1'b0, 15'd100, 16'h0});
    doRead(A0, d); check("R3 write clears count", d, enc(1'b0, 15'd100, 15'd0));
    waitTicks(3);
    doRead(A0, d); check("R4 three ticks", d, enc(1'b0, 15'd100, 15'd3));
    doWrite(A0, {1'b0, 15'd100, 16'h0});
    waitTicks(7);
    doRead(A0, d); check("R4 seven ticks", d, enc(1'b0, 15'd100, 15'd7));
  endtask

  task automatic testReset0();
    logic [31:0] d;
    int base;
    base = pulseCycles;
    doWrite(A0, {1'b1, 15'd3, 16'h0});
    waitTicks(2);
    doRead(A0, d); check("R5 below limit", d, enc(1'b1, 15'd3, 15'd2));
    check("R6 no pulse early", 32'(pulseCycles - base), 32'd0);
    waitTicks(1);
    repeat (2) @(negedge clk);
    doRead(A0, d); check("R5 at limit", d, enc(1'b1, 15'd3, 15'd3));
    check("R6 one pulse cycle", 32'(pulseCycles - base), 32'd1);
    waitTicks(5);
    doRead(A0, d); check("R5 holds at limit", d, enc(1'b1, 15'd3, 15'd3));
    check("R6 no repeat pulse", 32'(pulseCycles - base), 32'd1);
    base = pulseCycles;
    doWrite(A0, {1'b0, 15'd2, 16'h0});
    waitTicks(4);
    doRead(A0, d); check("R6 unarmed limit", d, enc(1'b0, 15'd2, 15'd2));
    check("R6 unarmed no pulse", 32'(pulseCycles - base), 32'd0);
  endtask

  task automatic testGuard();
    doWrite(A1, {1'b1, 15'd2, 16'h0});
    waitTicks(1);
    check("R7 guard low before", {31'h0, pktGuard}, 32'd0);
    waitTicks(1);
    check("R7 guard at expiry", {31'h0, pktGuard}, 32'd1);
    waitTicks(3);
    check("R7 guard stays", {31'h0, pktGuard}, 32'd1);
    doWrite(A1, {1'b0, 15'd2, 16'h0});
    check("R7 disarm drops", {31'h0, pktGuard}, 32'd0);
    waitTicks(3);
    check("R7 disarmed expiry low", {31'h0, pktGuard}, 32'd0);
    doWrite(A1, {1'b1, 15'd2, 16'h0});
    waitTicks(3);
    check("R7 rearmed high", {31'h0, pktGuard}, 32'd1);
    doWrite(A1, {1'b1, 15'd2, 16'h0});
    check("R7 clear drops", {31'h0, pktGuard}, 32'd0);
  endtask

  task automatic testZero();
    logic [31:0] d;
    int base;
    base = pulseCycles;
    doWrite(A0, {1'b1, 15'd0, 16'h0});
    doWrite(A1, {1'b1, 15'd0, 16'h0});
    waitTicks(5);
    doRead(A0, d); check("R8 ch0 stays 0", d, enc(1'b1, 15'd0, 15'd0));
    check("R8 no pulse", 32'(pulseCycles - base), 32'd0);
    check("R8 no guard", {31'h0, pktGuard}, 32'd0);
  endtask

  task automatic testIndep();
    logic [31:0] d;
    doWrite(A1, {1'b0, 15'd100, 16'h0});
    repeat (2 * DIV - 1) @(negedge clk);
    doWrite(A0, {1'b1, 15'd50, 16'h0});
    doRead(A1, d); check("R9 ch1 undisturbed", d, enc(1'b0, 15'd100, 15'd2));
    doRead(A0, d); check("R9 ch0 written", d, enc(1'b1, 15'd50, 15'd0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testLayout();
    testCount();
    testReset0();
    testGuard();
    testZero();
    testIndep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule